// File: doc/BRIEF.md
# Small-Width Left Bit Rotator

A purely combinational unit that rotates a 4-bit data word toward its most significant end. Each bit pushed past the top position comes back in at position 0. The rotation amount arrives on its own 4-bit input, which can take any value from 0 to 15. The effective rotation is that amount modulo the data width. Only the low bits of the amount steer the result, so amounts 4, 8 and 12 give back the data unchanged.

The result is built from a chain of two-way multiplexer stages. Stage k rotates by 2^k positions when amount bit k is set and passes its input through otherwise. No adder, comparator or other arithmetic operator appears in the datapath. There is no clock, no reset and no storage: the output follows the inputs after the mux delay. Bit 3 is the most significant bit of every word.

Top module: `rotl_mux_unit`

## Requirements
- R1: When amount_i modulo 4 is 0, rot_o equals data_i.
- R2: When amount_i modulo 4 is 1, rot_o is {data_i[2:0], data_i[3]}, so data 0101 gives 1010 and data 1000 gives 0001.
- R3: When amount_i modulo 4 is 2, rot_o is {data_i[1:0], data_i[3:2]}, so data 0100 gives 0001.
- R4: When amount_i modulo 4 is 3, rot_o is {data_i[0], data_i[3:1]}.
- R5: amount_i[3:2] has no effect. Amounts k, k+4, k+8 and k+12 give the same rot_o for the same data, and amounts 4, 8 and 12 return data_i unchanged.
- R6: rot_o always holds the same number of 1 bits as data_i. No bit is lost or filled in, as a shift would do.
- R7: For all 256 combinations of data_i and amount_i, rot_o[(i + amount_i) mod 4] equals data_i[i] for every bit position i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| data_i | input | 4 | Word to rotate; bit 3 is the MSB |
| amount_i | input | 4 | Rotation amount, 0 to 15, applied modulo 4 |
| rot_o | output | 4 | data_i rotated left by the amount |

## Verification
The bound checker evaluates the four rotation cases (R1 to R4) and the preservation of the 1-bit count (R6) on every input change, so any wrong mux route is caught as soon as it is exercised. It cannot show that the upper amount bits are ignored (R5), because that needs the same data compared under different amounts. The bench does this by driving each data word with all four aliases of an amount. The bench's exhaustive sweep over the full input space against an independent bit-placement model covers R7.

// File: rtl/rotl_pkg.sv
package rotl_pkg;
  localparam int unsigned ROT_DATA_W = 4;
  localparam int unsigned ROT_AMT_W  = 4;
endpackage

// File: rtl/rotl_mux2.sv
module rotl_mux2 (
  input  logic a_i,
  input  logic b_i,
  input  logic sel_i,
  output logic y_o
);
  assign y_o = sel_i ? b_i : a_i;
endmodule

// File: rtl/rotl_stage.sv
// One barrel stage: rotate left by SHIFT when sel_i is high.
module rotl_stage #(
  parameter int unsigned DATA_W = 4,
  parameter int unsigned SHIFT  = 1
) (
  input  logic [DATA_W-1:0] d_i,
  input  logic              sel_i,
  output logic [DATA_W-1:0] d_o
);
  localparam int unsigned SHIFT_M = SHIFT % DATA_W;

  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    localparam int unsigned SRC = (i + DATA_W - SHIFT_M) % DATA_W;
    rotl_mux2 i_mux (
      .a_i  (d_i[i]),
      .b_i  (d_i[SRC]),
      .sel_i(sel_i),
      .y_o  (d_o[i])
    );
  end
endmodule

// File: rtl/rotl_mux_unit.sv
module rotl_mux_unit
  import rotl_pkg::*;
#(
  parameter int unsigned DATA_W = ROT_DATA_W,
  parameter int unsigned AMT_W  = ROT_AMT_W
) (
  input  logic [DATA_W-1:0] data_i,
  input  logic [AMT_W-1:0]  amount_i,
  output logic [DATA_W-1:0] rot_o
);
  // DATA_W must be a power of two; upper amount bits then alias to zero.
  localparam int unsigned SEL_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam int unsigned USE_W = (SEL_W < AMT_W) ? SEL_W : AMT_W;

  logic [DATA_W-1:0] stage_q [USE_W+1];

  assign stage_q[0] = data_i;

  for (genvar k = 0; k < USE_W; k++) begin : g_stage
    rotl_stage #(
      .DATA_W(DATA_W),
      .SHIFT (1 << k)
    ) i_stage (
      .d_i  (stage_q[k]),
      .sel_i(amount_i[k]),
      .d_o  (stage_q[k+1])
    );
  end

  if (AMT_W > USE_W) begin : g_fold
    logic unused_amt_hi;
    assign unused_amt_hi = ^amount_i[AMT_W-1:USE_W];
  end

  assign rot_o = stage_q[USE_W];
endmodule

// File: rtl/rotl_mux_unit_chk.sv
module rotl_mux_unit_chk #(
  parameter int unsigned DATA_W = 4,
  parameter int unsigned AMT_W  = 4
) (
  input logic [DATA_W-1:0] data_i,
  input logic [AMT_W-1:0]  amount_i,
  input logic [DATA_W-1:0] rot_o
);
  localparam int unsigned SEL_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;

  function automatic logic [DATA_W-1:0] place(input logic [DATA_W-1:0] d, input int unsigned k);
    logic [DATA_W-1:0] r;
    for (int unsigned i = 0; i < DATA_W; i++) r[(i + k) % DATA_W] = d[i];
    return r;
  endfunction

  int unsigned amt_lo;
  assign amt_lo = int'(amount_i[SEL_W-1:0]);

  always_comb begin
    if (amt_lo == 0) AST_ZERO_AMT: assert (rot_o == data_i) else $error("rot by 0"); // R1
    if (amt_lo == 1) AST_ROT_ONE: assert (rot_o == place(data_i, 1)) else $error("rot by 1"); // R2
    if (amt_lo == 2) AST_ROT_TWO: assert (rot_o == place(data_i, 2)) else $error("rot by 2"); // R3
    if (amt_lo == 3) AST_ROT_THREE: assert (rot_o == place(data_i, 3)) else $error("rot by 3"); // R4
    AST_ONES_KEPT: assert ($countones(rot_o) == $countones(data_i)) else $error("ones count"); // R6
  end
endmodule

bind rotl_mux_unit rotl_mux_unit_chk #(.DATA_W(DATA_W), .AMT_W(AMT_W)) i_chk (
  .data_i  (data_i),
  .amount_i(amount_i),
  .rot_o   (rot_o)
);

// File: tb/test_rotl_mux_unit.sv
`timescale 1ns/1ps
module test_rotl_mux_unit;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [3:0] data_i = '0;
  logic [3:0] amount_i = '0;
  logic [3:0] rot_o;

  int unsigned n_cmp = 0;
  int unsigned n_bad = 0;
  bit          done = 1'b0;

  typedef struct {
    logic [3:0] exp;
    logic [3:0] din;
    bit         ones_only;
    string      req;
  } item_t;

  item_t exp_q[$];

  always #2.5 clk = ~clk;

  rotl_mux_unit i_rotl_mux_unit (
    .data_i  (data_i),
    .amount_i(amount_i),
    .rot_o   (rot_o)
  );

  // Reference: input bit i lands at output position (i + amount) mod 4.
  function automatic logic [3:0] model(input logic [3:0] d, input int unsigned a);
    logic [3:0] r;
    for (int unsigned i = 0; i < 4; i++) r[(i + a) % 4] = d[i];
    return r;
  endfunction

  task automatic drive(input logic [3:0] d, input logic [3:0] a, input logic [3:0] e,
                       input string req, input bit ones_only = 1'b0);
    item_t it;
    @(posedge clk);
    data_i   <= d;
    amount_i <= a;
    it.exp = e; it.din = d; it.ones_only = ones_only; it.req = req;
    exp_q.push_back(it);
  endtask

  // Monitor: inputs change at posedge, compare at negedge.
  always @(negedge clk) begin
    if (rst_ni && exp_q.size() > 0) begin
      item_t it;
      it = exp_q.pop_front();
      n_cmp++;
      if (it.ones_only) begin
        if ($countones(rot_o) != $countones(it.din)) begin
          n_bad++;
          $display("FAIL %s: ones actual %0d expected %0d", it.req, $countones(rot_o), $countones(it.din));
        end
      end else if (rot_o !== it.exp) begin
        n_bad++;
        $display("FAIL %s: data=%b amt=%0d actual %b expected %b", it.req, it.din, amount_i, rot_o, it.exp);
      end
    end
  end

  initial begin
    #1000000;
    if (!done) begin
      n_bad++; n_cmp++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    n_cmp++;
    if (rot_o !== 4'b0000) begin
      n_bad++;
      $display("FAIL R1 reset: actual %b expected 0000", rot_o);
    end
    rst_ni = 1'b1;

    drive(4'b1011, 4'd0, 4'b1011, "R1");
    drive(4'b0101, 4'd1, 4'b1010, "R2");
    drive(4'b1000, 4'd1, 4'b0001, "R2");
    drive(4'b0100, 4'd2, 4'b0001, "R3");
    drive(4'b1001, 4'd2, 4'b0110, "R3");
    drive(4'b0001, 4'd3, 4'b1000, "R4");
    drive(4'b1100, 4'd3, 4'b0110, "R4");
    drive(4'b0110, 4'd4, 4'b0110, "R5");
    drive(4'b0110, 4'd8, 4'b0110, "R5");
    drive(4'b0110, 4'd12, 4'b0110, "R5");
    drive(4'b0011, 4'd13, 4'b0110, "R5");
    drive(4'b0011, 4'd15, 4'b1001, "R5");

    for (int d = 0; d < 16; d++)
      for (int k = 0; k < 4; k++)
        for (int h = 0; h < 4; h++)
          drive(4'(d), 4'(k + 4*h), model(4'(d), k), "R5");

    for (int d = 0; d < 16; d++)
      drive(4'(d), 4'(d * 7 + 1), '0, "R6", 1'b1);

    for (int d = 0; d < 16; d++)
      for (int a = 0; a < 16; a++)
        drive(4'(d), 4'(a), model(4'(d), a), "R7");

    @(posedge clk);
    @(posedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule